// File: doc/BRIEF.md
# Ramp Conversion Controller with Offset Capture

This block sequences the ramp-compare (Wilkinson) digitisation of one sampling channel. The channel holds 65 analog cells: 64 waveform cells and a final cell that carries a time-over-threshold value. A shared timebase counter runs at all times and is never cleared between conversions. When a conversion begins, the controller records the counter as the ramp-start offset. While the ramp rises, each cell's comparator fires once, and the controller stores the counter value for that cell. The conversion ends on the first edge at which every comparator has fired, so dead time lasts only as long as the tallest sample needs.

A conversion is started by the channel trigger when automatic mode is on, and by an explicit command when it is off. In automatic mode the stored codes already have the offset removed. The subtraction is modulo the counter width, so a conversion that spans a counter wrap still gives the correct code. In command mode the stored codes are the raw counter bits. Resolution can be set from 7 to 11 bits. If the full-scale window runs out before every comparator has fired, the cells still unconverted are forced to the maximum code and a saturation flag is raised.

Top module: `wilk_conv_ctrl`

## Requirements
- R1: `tb_count` is 0 during reset and increments by one on every clock edge after reset, wrapping modulo 2^CNT_W (4096 by default).
- R2: While idle, a conversion starts at the clock edge where `trig` is high (if `auto_en`=1) or `conv_cmd` is high (if `auto_en`=0). The input belonging to the other mode is ignored. `busy` is high from the following cycle.
- R3: `offset` takes the value `tb_count` had in the cycle in which the start was sampled, and it holds that value until the next start.
- R4: During a conversion, the first edge at which `cmp_fire[i]` is high stores a code into cell i (`cell_data[i*11 +: 11]`). Later values of `cmp_fire[i]` in the same conversion have no effect.
- R5: When the mode latched at start is automatic, the stored code is (tb_count − offset) mod 2^CNT_W, masked to the resolution. In command mode it is tb_count masked to the resolution.
- R6: `res_sel` is latched at start. A value v from 0 to 4 selects 7+v bits; any value from 5 to 7 selects 11 bits. The mask is 2^bits − 1.
- R7: At the edge where every cell has fired, `busy` falls and `done` is high for exactly one cycle.
- R8: If (tb_count − offset) reaches 2^bits − 1 at an edge while some cells are still unfired and not firing at that edge, those cells get the code 2^bits − 1, `sat` is set, and the conversion ends with a `done` pulse. The busy period therefore never exceeds 2^bits − 1 cycles.
- R9: A start clears every cell code and `sat` to 0.
- R10: Start inputs that arrive while `busy` is high are ignored, and `offset` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_en | input | 1 | 1 = trigger-started with offset removal, 0 = command-started raw codes |
| trig | input | 1 | Channel trigger (start in automatic mode) |
| conv_cmd | input | 1 | Start command (start in command mode) |
| res_sel | input | 3 | Resolution select, 7+v bits, saturating at 11 |
| cmp_fire | input | 65 | Cell comparator outputs; bit 64 is the time-over-threshold cell |
| tb_count | output | 12 | Free-running shared timebase |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| sat | output | 1 | Full scale elapsed before all comparators fired |
| offset | output | 12 | Timebase value captured at ramp start |
| cell_data | output | 715 | 65 cell codes of 11 bits each, cell i at bits i*11 upward |

## Verification
The bench runs conversions whose comparator fire times are drawn at random for every resolution setting and both modes. These are mixed with directed patterns: every cell firing on the first ramp cycle (minimum code, earliest end), every cell firing together late, a few cells that never fire (separates a normal end from saturation), and a conversion launched just before the counter wraps (shows that the offset subtraction is modular). Comparator outputs are toggled after their first edge, and start inputs of both kinds are driven while busy. These patterns show whether codes are captured only once and whether a running conversion can be restarted.

// File: rtl/wilk_conv_ctrl.sv
module wilk_conv_ctrl #(
  parameter int NCELL  = 65,
  parameter int CNT_W  = 12,
  parameter int MINRES = 7,
  parameter int MAXRES = 11
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      auto_en,
  input  logic                      trig,
  input  logic                      conv_cmd,
  input  logic [2:0]                res_sel,
  input  logic [NCELL-1:0]          cmp_fire,
  output logic [CNT_W-1:0]          tb_count,
  output logic                      busy,
  output logic                      done,
  output logic                      sat,
  output logic [CNT_W-1:0]          offset,
  output logic [NCELL*MAXRES-1:0]   cell_data
);
  localparam int BW = $clog2(MAXRES + 1);

  logic [CNT_W-1:0]  cnt, diff, mask;
  logic [BW-1:0]     bits_q, sel_bits;
  logic              mode_q, start, all_in, timeout;
  logic [NCELL-1:0]  fired, newfire;
  logic [MAXRES-1:0] code;
  logic [MAXRES-1:0] cell_q [NCELL];

  assign sel_bits = (int'(res_sel) > MAXRES - MINRES) ? BW'(MAXRES) : BW'(MINRES + int'(res_sel));
  assign start    = !busy && (auto_en ? trig : conv_cmd);
  assign diff     = cnt - offset;
  assign mask     = (CNT_W'(1) << bits_q) - CNT_W'(1);
  assign code     = MAXRES'((mode_q ? diff : cnt) & mask);
  assign newfire  = cmp_fire & ~fired;
  assign all_in   = &(fired | newfire);
  assign timeout  = (diff == mask);
  assign tb_count = cnt;

  for (genvar g = 0; g < NCELL; g++) begin : g_out
    assign cell_data[g*MAXRES +: MAXRES] = cell_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      sat    <= 1'b0;
      offset <= '0;
      mode_q <= 1'b0;
      bits_q <= BW'(MAXRES);
      fired  <= '0;
      for (int i = 0; i < NCELL; i++) cell_q[i] <= '0;
    end else begin
      cnt  <= cnt + CNT_W'(1);
      done <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        offset <= cnt;
        mode_q <= auto_en;
        bits_q <= sel_bits;
        fired  <= '0;
        sat    <= 1'b0;
        for (int i = 0; i < NCELL; i++) cell_q[i] <= '0;
      end else if (busy) begin
        for (int i = 0; i < NCELL; i++) begin
          if (newfire[i])
            cell_q[i] <= code;
          else if (timeout && !fired[i])
            cell_q[i] <= MAXRES'(mask);
        end
        fired <= fired | newfire;
        if (all_in || timeout) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (!all_in) sat <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wilk_conv_ctrl_chk.sv
module wilk_conv_ctrl_chk #(
  parameter int CNT_W  = 12,
  parameter int MAXRES = 11
)(
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tb_count,
  input logic             busy,
  input logic             done,
  input logic             sat,
  input logic [CNT_W-1:0] offset
);
  logic [CNT_W:0] blen;
  logic           run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen <= '0;
      run  <= 1'b0;
    end else begin
      run  <= 1'b1;
      blen <= busy ? blen + 1'b1 : '0;
    end
  end

  AST_COUNT_STEP:   assert property (@(posedge clk) disable iff (!rst_n) run |-> tb_count == $past(tb_count) + CNT_W'(1)); // R1
  AST_OFFSET_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (run && busy && $past(busy)) |-> $stable(offset)); // R10
  AST_DONE_END:     assert property (@(posedge clk) disable iff (!rst_n) (run && done) |-> (!busy && $past(busy))); // R7
  AST_DONE_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_SAT_AT_END:   assert property (@(posedge clk) disable iff (!rst_n) (run && $rose(sat)) |-> done); // R8
  AST_BUSY_BOUND:   assert property (@(posedge clk) disable iff (!rst_n) busy |-> blen < (CNT_W+1)'(2**MAXRES)); // R8
endmodule

bind wilk_conv_ctrl wilk_conv_ctrl_chk #(.CNT_W(CNT_W), .MAXRES(MAXRES)) chk_i (
  .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .busy(busy),
  .done(done), .sat(sat), .offset(offset)
);

// File: tb/wilk_conv_ctrl_tb.sv
module wilk_conv_ctrl_tb_top;
  localparam int NCELL = 65, CNT_W = 12, MINRES = 7, MAXRES = 11, NEVER = 100000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic auto_en = 1'b0, trig = 1'b0, conv_cmd = 1'b0;
  logic [2:0] res_sel = '0;
  logic [NCELL-1:0] cmp = '0;
  logic [CNT_W-1:0] tb_count, offset;
  logic busy, done, sat;
  logic [NCELL*MAXRES-1:0] cell_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  int ft [NCELL];
  int ex [NCELL];

  always #4 clk = ~clk;

  wilk_conv_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .trig(trig), .conv_cmd(conv_cmd),
    .res_sel(res_sel), .cmp_fire(cmp), .tb_count(tb_count), .busy(busy), .done(done),
    .sat(sat), .offset(offset), .cell_data(cell_data)
  );

  function automatic int bits_of(int v);
    return (v > MAXRES - MINRES) ? MAXRES : MINRES + v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(bit mode, int rsel, bit noise);
    int msk, off, c, d, satx;
    bit fin;
    bit fd [NCELL];
    msk = (1 << bits_of(rsel)) - 1;
    satx = 0;
    fin = 0;
    for (int i = 0; i < NCELL; i++) fd[i] = 0;
    @(negedge clk);
    auto_en = mode; res_sel = 3'(rsel);
    trig = mode; conv_cmd = !mode;
    off = int'(tb_count);
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    while (!fin) begin
      c = int'(tb_count);
      d = (c - off) & ((1 << CNT_W) - 1);
      trig = noise ? 1'($urandom % 2) : 1'b0;
      conv_cmd = noise ? 1'($urandom % 2) : 1'b0;
      for (int i = 0; i < NCELL; i++) begin
        if (d == ft[i]) cmp[i] = 1'b1;
        else if (d > ft[i]) cmp[i] = 1'($urandom % 2);
        else cmp[i] = 1'b0;
        if (!fd[i] && d >= ft[i]) begin
          fd[i] = 1;
          ex[i] = mode ? (d & msk) : (c & msk);
        end
      end
      fin = 1;
      for (int i = 0; i < NCELL; i++) if (!fd[i]) fin = 0;
      if (!fin && d == msk) begin
        for (int i = 0; i < NCELL; i++) if (!fd[i]) ex[i] = msk;
        satx = 1;
        fin = 1;
      end
      @(negedge clk);
    end
    trig = 1'b0; conv_cmd = 1'b0; cmp = '0;
    chk(done == 1'b1, "R7 done pulse", int'(done), 1);
    chk(busy == 1'b0, "R7 busy falls", int'(busy), 0);
    chk(int'(sat) == satx, "R8 sat flag", int'(sat), satx);
    chk(int'(offset) == off, "R3/R10 offset", int'(offset), off);
    for (int i = 0; i < NCELL; i++)
      chk(int'(cell_data[i*MAXRES +: MAXRES]) == ex[i], "R4/R5/R6/R8 cell code",
          int'(cell_data[i*MAXRES +: MAXRES]), ex[i]);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7 done one cycle, R10 no restart", int'({busy, done}), 0);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int a, b, m;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(tb_count == '0 && busy == 1'b0 && done == 1'b0 && sat == 1'b0, "R1 reset state",
        int'(tb_count), 0);
    rst_n = 1'b1;
    @(negedge clk); a = int'(tb_count);
    @(negedge clk); b = int'(tb_count);
    chk(b == ((a + 1) & 4095), "R1 counter step", b, (a + 1) & 4095);

    // R2: inputs of the inactive mode are ignored while idle
    auto_en = 1'b1; conv_cmd = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2 conv_cmd ignored in auto", int'(busy), 0);
    conv_cmd = 1'b0; auto_en = 1'b0; trig = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2 trig ignored in command mode", int'(busy), 0);
    trig = 1'b0;

    // all fire at the first ramp cycle
    for (int i = 0; i < NCELL; i++) ft[i] = 1;
    run_conv(1'b1, 4, 1'b0);
    // all fire together, late, 7-bit command mode
    for (int i = 0; i < NCELL; i++) ft[i] = 100;
    run_conv(1'b0, 0, 1'b0);
    // some cells never fire -> saturation, R9 clears on next start
    for (int i = 0; i < NCELL; i++) ft[i] = (i % 9 == 3) ? NEVER : 1 + i;
    run_conv(1'b1, 1, 1'b1);
    for (int i = 0; i < NCELL; i++) ft[i] = 2 + (i % 5);
    run_conv(1'b1, 2, 1'b0);
    chk(sat == 1'b0, "R9 sat cleared", int'(sat), 0);
    // time-over-threshold cell alone is last
    for (int i = 0; i < NCELL; i++) ft[i] = (i == NCELL - 1) ? 300 : 5;
    run_conv(1'b1, 7, 1'b1);

    // R1 wrap and R5 modular subtraction across the wrap
    while (tb_count != 12'd4095) @(negedge clk);
    @(negedge clk);
    chk(tb_count == '0, "R1 wrap", int'(tb_count), 0);
    while (tb_count != 12'd4000) @(negedge clk);
    for (int i = 0; i < NCELL; i++) ft[i] = 50 + 3 * i;
    run_conv(1'b1, 4, 1'b1);
    while (tb_count != 12'd4050) @(negedge clk);
    for (int i = 0; i < NCELL; i++) ft[i] = 20 + i;
    run_conv(1'b0, 3, 1'b0);

    // random mix
    for (int k = 0; k < 30; k++) begin
      int rs;
      rs = int'($urandom % 8);
      m = (1 << bits_of(rs)) - 1;
      for (int i = 0; i < NCELL; i++)
        ft[i] = ($urandom % 25 == 0) ? NEVER : 1 + int'($urandom % (m - 1));
      run_conv(1'($urandom % 2), rs, 1'($urandom % 2));
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule